// File: doc/BRIEF.md
# Quad Power-Good Sequencer

This synchronous controller releases four power-good enables, one after another, once the input supply sits inside its allowed window. The window is reported by two external comparator levels, "under-voltage OK" and "over-voltage fault". A third level reports that the internal supply is ready. All three levels are synchronized inside the block.

When the window holds, a power-on-reset ramp timer runs first. When it ends, flag A is released. Each of flags B, C and D follows its predecessor after 255 full cycles of an oscillator. A full cycle is a charge half and a discharge half, and each half lasts a programmable number of clocks. If the window is lost at any time, every flag drops together and the ramp is cleared. A new sequence starts as soon as the window returns.

Each flag models an open-drain pin. It has an enable bit, plus an active-low output enable that pulls the pin low while the flag is inactive. A 3-bit state output shows the progress of the sequence. A second instance can use flag D as its own window input to chain eight rails.

Top module: `pg_sequencer`

## Requirements
- R1: After reset, and while the synchronized supply-ready level is low, all flags are inactive and state_o is IDLE (0).
- R2: Each of the three levels passes through two flip-flops. A change applied before rising edge k first moves state_o at edge k+2.
- R3: A sequence starts only when uv_ok_i=1, ov_flt_i=0 and uvlo_ok_i=1. State RAMP (1) lasts por_len_i cycles, and flag A (bit 0) rises por_len_i edges after RAMP is entered.
- R4: Flags rise strictly in the order bit 0 (A), bit 1 (B), bit 2 (C), bit 3 (D), giving the patterns 0001, 0011, 0111, 1111.
- R5: Flag B, C or D rises 510*H clock edges after the previous flag rose, where H is the half-period divisor of that stage (255 cycles of two halves).
- R6: A stage's divisor is sampled when the stage is entered. A change during the stage does not move its end.
- R7: A divisor of 0 acts as 1, and a ramp length of 0 acts as 1.
- R8: Losing the window in any non-idle state clears all flags at one edge, returns state_o to IDLE, and clears the ramp. The next ramp runs its full length.
- R9: The fault path has no filter. A violation held for a single clock cycle drops all flags.
- R10: When the synchronized window is good in IDLE, state_o becomes RAMP at the next edge.
- R11: pg_oe_n_o[i] is 0 (pin driven low) while flag i is inactive, and 1 (pin released) while it is active.
- R12: The state codes are IDLE 0, RAMP 1, WAIT_B 2, WAIT_C 3, WAIT_D 4 and DONE 5. DONE holds while the window stays good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Under-voltage comparator reports OK |
| ov_flt_i | input | 1 | Over-voltage comparator reports a fault |
| uvlo_ok_i | input | 1 | Internal supply ready |
| por_len_i | input | 24 | Ramp length in clock cycles |
| half_b_i | input | 16 | Half-period divisor for stage B |
| half_c_i | input | 16 | Half-period divisor for stage C |
| half_d_i | input | 16 | Half-period divisor for stage D |
| pg_en_o | output | 4 | Flag active bits, bit 0 = A |
| pg_oe_n_o | output | 4 | Active-low drive enable per pin |
| state_o | output | 3 | Sequence state code |

## Verification
The bench measures every flag edge to the exact cycle. A miscounted synchronizer, ramp or stage timer therefore shows up as an early or late event.

Faults are injected in DONE, in the middle of the ramp, and in WAIT_C. A ramp that is not cleared would release A early after recovery. A filter on the fault path would ignore the one-cycle glitch.

A divisor is changed in the middle of a stage to catch a timer that reads it live. Zero divisors and a zero ramp length are applied to catch a timer that hangs or wraps.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;
  localparam int unsigned NUM_FLAGS = 4;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RAMP   = 3'd1,
    ST_WAIT_B = 3'd2,
    ST_WAIT_C = 3'd3,
    ST_WAIT_D = 3'd4,
    ST_DONE   = 3'd5
  } pg_state_e;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pg_ramp_timer.sv
module pg_ramp_timer #(
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? LEN_W'(1) : len_i;
  assign done_o  = run_i && (cnt_q >= len_eff - LEN_W'(1));

  // counter is held at zero whenever the ramp is not running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + LEN_W'(1);
  end
endmodule

// File: rtl/pg_stage_timer.sv
module pg_stage_timer #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [HALF_W-1:0] half_q, hc_q;
  logic              ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              half_end;

  assign half_end = (hc_q == half_q - HALF_W'(1));
  assign done_o   = run_i && half_end && ph_q && (cnt_q == CNT_LAST - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_W'(1);
      hc_q   <= '0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      half_q <= (half_i == '0) ? HALF_W'(1) : half_i;
      hc_q   <= '0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
    end else if (run_i) begin
      if (half_end) begin
        hc_q <= '0;
        ph_q <= ~ph_q;
        if (ph_q) cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        hc_q <= hc_q + HALF_W'(1);
      end
    end
  end

  // R5: the cycle counter never passes its terminal count while a stage runs
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < CNT_LAST));
endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer
  import pg_seq_pkg::*;
#(
  parameter int unsigned RAMP_W = 24,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 uv_ok_i,
  input  logic                 ov_flt_i,
  input  logic                 uvlo_ok_i,
  input  logic [RAMP_W-1:0]    por_len_i,
  input  logic [HALF_W-1:0]    half_b_i,
  input  logic [HALF_W-1:0]    half_c_i,
  input  logic [HALF_W-1:0]    half_d_i,
  output logic [NUM_FLAGS-1:0] pg_en_o,
  output logic [NUM_FLAGS-1:0] pg_oe_n_o,
  output logic [2:0]           state_o
);
  logic [2:0]        lvl_s;
  logic              uv_s, ov_s, uvlo_s, win_ok;
  pg_state_e         state_q, state_d;
  logic              ramp_done, stg_done, stg_load, stg_run;
  logic [HALF_W-1:0] half_sel;

  pg_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({uvlo_ok_i, ov_flt_i, uv_ok_i}),
    .q_o   (lvl_s)
  );
  assign {uvlo_s, ov_s, uv_s} = lvl_s;
  assign win_ok = uv_s && !ov_s && uvlo_s;

  pg_ramp_timer #(.LEN_W(RAMP_W)) u_ramp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q == ST_RAMP),
    .len_i (por_len_i),
    .done_o(ramp_done)
  );

  always_comb begin
    state_d = state_q;
    if (!win_ok) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE:   state_d = ST_RAMP;
        ST_RAMP:   if (ramp_done) state_d = ST_WAIT_B;
        ST_WAIT_B: if (stg_done)  state_d = ST_WAIT_C;
        ST_WAIT_C: if (stg_done)  state_d = ST_WAIT_D;
        ST_WAIT_D: if (stg_done)  state_d = ST_DONE;
        default:   state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // divisor for the stage about to start is latched on entry
  always_comb begin
    unique case (state_d)
      ST_WAIT_B: half_sel = half_b_i;
      ST_WAIT_C: half_sel = half_c_i;
      default:   half_sel = half_d_i;
    endcase
  end
  assign stg_load = (state_d != state_q) &&
                    (state_d inside {ST_WAIT_B, ST_WAIT_C, ST_WAIT_D});
  assign stg_run  = state_q inside {ST_WAIT_B, ST_WAIT_C, ST_WAIT_D};

  pg_stage_timer #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(stg_load),
    .run_i (stg_run),
    .half_i(half_sel),
    .done_o(stg_done)
  );

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    assign pg_en_o[gi]   = (3'(state_q) >= 3'(ST_WAIT_B) + 3'(gi));
    assign pg_oe_n_o[gi] = pg_en_o[gi];
    if (gi > 0) begin : g_order
      // R4: a flag rises only when its predecessor is already active
      a_r4_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pg_en_o[gi]) |-> $past(pg_en_o[gi-1]));
    end
  end

  assign state_o = state_q;

  // R1
  a_r1_uvlo_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uvlo_s |=> (state_q == ST_IDLE));
  // R3
  a_r3_a_after_ramp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pg_en_o[0]) |-> ($past(state_q) == ST_RAMP));
  // R8
  a_r8_fault_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_ok |=> (pg_en_o == '0));
  // R10
  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && win_ok) |=> (state_q == ST_RAMP));
endmodule

// File: tb/sim_pg_sequencer.sv
`timescale 1ns/1ps
module sim_pg_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        uv_ok, ov_flt, uvlo_ok;
  logic [23:0] por_len;
  logic [15:0] hb, hc, hd;
  logic [3:0]  pg_en, pg_oe_n;
  logic [2:0]  state;

  always #2 clk = ~clk;

  pg_sequencer u0 (
    .clk_i(clk), .rst_ni(rst_n), .uv_ok_i(uv_ok), .ov_flt_i(ov_flt),
    .uvlo_ok_i(uvlo_ok), .por_len_i(por_len), .half_b_i(hb), .half_c_i(hc),
    .half_d_i(hd), .pg_en_o(pg_en), .pg_oe_n_o(pg_oe_n), .state_o(state)
  );

  typedef struct {int t; logic [3:0] en; string tag;} exp_t;
  exp_t q[$];
  exp_t e;
  int cyc = 0, checks = 0, errors = 0;
  bit mon_on = 1'b0;
  logic [3:0] prev = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp_v, cyc);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // monitor: every flag change must match the next expected event
  always @(negedge clk) begin
    if (mon_on && pg_en != prev) begin
      if (q.size() == 0) chk(1'b0, "R4", "unexpected flag change", pg_en, prev);
      else begin
        e = q.pop_front();
        chk(pg_en == e.en, e.tag, "flag pattern", pg_en, e.en);
        chk(cyc == e.t, e.tag, "event cycle", cyc, e.t);
      end
      chk(pg_oe_n == pg_en, "R11", "oe_n vs flag", pg_oe_n, pg_en);
      prev = pg_en;
    end
  end

  task automatic expect_seq(input int t0, input int n, input int b, input int c, input int d);
    int t;
    t = t0 + 3 + eff(n);          q.push_back('{t, 4'b0001, "R3"});
    t = t + 510 * eff(b);         q.push_back('{t, 4'b0011, "R5"});
    t = t + 510 * eff(c);         q.push_back('{t, 4'b0111, "R5"});
    t = t + 510 * eff(d);         q.push_back('{t, 4'b1111, "R5"});
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_state(input logic [2:0] s);
    while (state != s) @(negedge clk);
  endtask

  initial begin
    wait (cyc >= 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    finish_sim();
  end

  initial begin
    int t0, t1;
    rst_n = 1'b0; uv_ok = 1'b1; ov_flt = 1'b0; uvlo_ok = 1'b0;
    por_len = 24'd20; hb = 16'd1; hc = 16'd2; hd = 16'd3;
    repeat (3) @(negedge clk);
    chk(pg_en == 4'b0000, "R1", "flags in reset", pg_en, 0);
    chk(pg_oe_n == 4'b0000, "R11", "oe_n in reset", pg_oe_n, 0);
    chk(state == 3'd0, "R1", "state in reset", state, 0);
    rst_n = 1'b1; mon_on = 1'b1;
    repeat (50) @(negedge clk);
    chk(state == 3'd0, "R1", "idle while uvlo low", state, 0);

    // full sequence; stage B divisor changed mid-stage (R6)
    @(negedge clk); uvlo_ok = 1'b1; t0 = cyc;
    expect_seq(t0, 20, 1, 2, 3);
    repeat (2) @(negedge clk);
    chk(state == 3'd0, "R2", "no move before third edge", state, 0);
    @(negedge clk);
    chk(state == 3'd1, "R10", "ramp at third edge", state, 1);
    wait_state(3'd2);
    hb = 16'd100;
    drain();
    chk(state == 3'd5, "R12", "done state held", state, 5);

    // over-voltage in DONE, restart with zero divisor (R7, R8)
    hb = 16'd0;
    @(negedge clk); ov_flt = 1'b1; t0 = cyc;
    q.push_back('{t0 + 3, 4'b0000, "R8"});
    repeat (3) @(negedge clk);
    chk(state == 3'd0, "R8", "idle after fault", state, 0);
    repeat (7) @(negedge clk); ov_flt = 1'b0; t1 = cyc;
    expect_seq(t1, 20, 0, 2, 3);
    drain();

    // one-cycle glitch, zero ramp length (R9, R7)
    por_len = 24'd0;
    @(negedge clk); uv_ok = 1'b0; t0 = cyc;
    @(negedge clk); uv_ok = 1'b1; t1 = cyc;
    q.push_back('{t0 + 3, 4'b0000, "R9"});
    expect_seq(t1, 0, 0, 2, 3);
    drain();

    // fault in DONE, then again during ramp: ramp must restart in full (R8)
    por_len = 24'd40;
    @(negedge clk); uv_ok = 1'b0; t0 = cyc;
    q.push_back('{t0 + 3, 4'b0000, "R8"});
    repeat (10) @(negedge clk); uv_ok = 1'b1; t1 = cyc;
    repeat (3) @(negedge clk);
    chk(state == 3'd1, "R10", "ramp after recovery", state, 1);
    repeat (20) @(negedge clk); uv_ok = 1'b0;
    repeat (3) @(negedge clk);
    chk(state == 3'd0, "R8", "ramp aborted", state, 0);
    uv_ok = 1'b1; t1 = cyc;
    expect_seq(t1, 40, 0, 2, 3);
    drain();

    // fault during WAIT_C (R8)
    @(negedge clk); ov_flt = 1'b1; t0 = cyc;
    q.push_back('{t0 + 3, 4'b0000, "R8"});
    repeat (5) @(negedge clk); ov_flt = 1'b0; t1 = cyc;
    expect_seq(t1, 40, 0, 2, 3);
    wait_state(3'd3);
    @(negedge clk); ov_flt = 1'b1; t0 = cyc;
    // pop the pending C/D events, replace with the fault
    q.delete();
    q.push_back('{t0 + 3, 4'b0000, "R8"});
    repeat (5) @(negedge clk); ov_flt = 1'b0; t1 = cyc;
    expect_seq(t1, 40, 0, 2, 3);
    drain();
    chk(state == 3'd5, "R12", "final done", state, 5);
    chk(q.size() == 0, "R4", "all events seen", q.size(), 0);
    finish_sim();
  end
endmodule